// File: doc/BRIEF.md
# Paged Program Counter Unit

This unit holds the 13-bit instruction address for an 8K-word program store. Each cycle a control opcode picks the next address. It can step to the next address, load a computed low byte, make an 11-bit immediate jump or call, return through a hardware stack, or enter the interrupt vector.

The upper address bits come from a 5-bit page latch that software writes. A write to the low byte copies the whole latch into address bits 12:8. An immediate jump or call uses only latch bits 4:3, which pick one of four 2K pages. The return stack is 8 entries deep and circular. When it is full, a further push silently replaces the oldest entry.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low, and after reset, `pc` is 0 and the page latch is 0. A low-byte write before any latch write therefore yields an address of the form 0x0XX.
- R2: Opcode 0 (step) makes `pc` equal the old `pc` + 1 on the next cycle, wrapping 0x1FFF to 0x0000.
- R3: When `latch_we` is 1, the latch takes `wr_data[4:0]` at the clock edge. The latch write does not change `pc` by itself. An operation in the same cycle still uses the old latch value.
- R4: Opcode 1 (low-byte write) loads `pc` with {latch[4:0], wr_data[7:0]}. No carry is taken from low-byte arithmetic.
- R5: Opcode 2 (jump) loads `pc` with {latch[4:3], imm[10:0]}. Latch bits 2:0 have no effect.
- R6: Opcode 3 (call) pushes the old `pc` + 1 and loads `pc` as a jump does. Opcode 4 (return) loads `pc` with the most recently pushed entry and pops it.
- R7: Nested calls return in last-in, first-out order.
- R8: The stack holds 8 entries and is circular. After 9 pushes with no pops, 9 returns yield the 9th, 8th, ..., 2nd pushed values, then the 9th again. No error is raised.
- R9: Opcode 5 (interrupt) pushes the current `pc` unchanged and loads `pc` with 0x004.
- R10: Opcodes 6 and 7 leave `pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Control opcode (0 step, 1 low write, 2 jump, 3 call, 4 return, 5 interrupt, 6/7 hold) |
| imm | input | 11 | Immediate target for jump and call |
| wr_data | input | 8 | Data for a low-byte write; bits 4:0 also feed the page latch |
| latch_we | input | 1 | Page latch write enable |
| pc | output | 13 | Current program address |

## Verification
The bench builds the unit with its default parameters: a 13-bit address, an 11-bit immediate and an 8-deep stack. With these values a low-byte write can place the counter at 0x1FFF, so the step from there tests the wrap to zero. A chain of nine calls is also short enough to overrun the stack, which tests the overwrite of the oldest entry. Page bits are driven with latch values whose bits 2:0 are non-zero, so a jump that wrongly used those bits would be caught.

// File: rtl/paged_pc.sv
module paged_pc #(
  parameter int PC_W    = 13,
  parameter int LOW_W   = 8,
  parameter int IMM_W   = 11,
  parameter int DEPTH   = 8,
  parameter int VEC     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op,
  input  logic [IMM_W-1:0]  imm,
  input  logic [LOW_W-1:0]  wr_data,
  input  logic              latch_we,
  output logic [PC_W-1:0]   pc
);
  localparam int LATCH_W = PC_W - LOW_W;
  localparam int PAGE_W  = PC_W - IMM_W;
  localparam int SP_W    = $clog2(DEPTH);

  logic [LATCH_W-1:0] latch_q;
  logic [SP_W-1:0]    sp;
  logic [PC_W-1:0]    stk [DEPTH];

  wire [SP_W-1:0]   sp_dn  = sp - 1'b1;
  wire [PC_W-1:0]   pc_inc = pc + 1'b1;
  wire [PC_W-1:0]   far    = {latch_q[LATCH_W-1 -: PAGE_W], imm};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc      <= '0;
      latch_q <= '0;
      sp      <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      if (latch_we) latch_q <= wr_data[LATCH_W-1:0];
      case (op)
        3'd0: pc <= pc_inc;
        3'd1: pc <= {latch_q, wr_data};
        3'd2: pc <= far;
        3'd3: begin
          stk[sp] <= pc_inc;
          sp      <= sp + 1'b1;
          pc      <= far;
        end
        3'd4: begin
          pc <= stk[sp_dn];
          sp <= sp_dn;
        end
        3'd5: begin
          stk[sp] <= pc;
          sp      <= sp + 1'b1;
          pc      <= PC_W'(VEC);
        end
        default: pc <= pc;
      endcase
    end
  end
endmodule

module paged_pc_chk #(
  parameter int PC_W  = 13,
  parameter int LOW_W = 8,
  parameter int IMM_W = 11,
  parameter int VEC   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op,
  input logic [IMM_W-1:0] imm,
  input logic [LOW_W-1:0] wr_data,
  input logic [PC_W-1:0]  pc
);
  AST_RESET_PC:   assert property (@(posedge clk) !rst_n |=> pc == '0); // R1
  AST_STEP:       assert property (@(posedge clk) disable iff (!rst_n) op == 3'd0 |=> pc == PC_W'($past(pc) + 1'b1)); // R2
  AST_LOW_WRITE:  assert property (@(posedge clk) disable iff (!rst_n) op == 3'd1 |=> pc[LOW_W-1:0] == $past(wr_data)); // R4
  AST_JUMP_LOW:   assert property (@(posedge clk) disable iff (!rst_n) op == 3'd2 |=> pc[IMM_W-1:0] == $past(imm)); // R5
  AST_CALL_LOW:   assert property (@(posedge clk) disable iff (!rst_n) op == 3'd3 |=> pc[IMM_W-1:0] == $past(imm)); // R6
  AST_VECTOR:     assert property (@(posedge clk) disable iff (!rst_n) op == 3'd5 |=> pc == PC_W'(VEC)); // R9
  AST_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) op[2:1] == 2'b11 |=> $stable(pc)); // R10
endmodule

bind paged_pc paged_pc_chk #(.PC_W(PC_W), .LOW_W(LOW_W), .IMM_W(IMM_W), .VEC(VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .wr_data(wr_data), .pc(pc)
);

// File: tb/paged_pc_tb.sv
module paged_pc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd6;
  logic [10:0] imm = '0;
  logic [7:0]  wr_data = '0;
  logic        latch_we = 1'b0;
  logic [12:0] pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [12:0] exp_q[$];
  string       tag_q[$];

  logic [12:0] m_pc = '0;
  logic [4:0]  m_latch = '0;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp = '0;

  always #5 clk = ~clk;

  paged_pc u_dut (.clk(clk), .rst_n(rst_n), .op(op), .imm(imm), .wr_data(wr_data),
                  .latch_we(latch_we), .pc(pc));

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [12:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc !== e) begin
        errors++;
        $display("FAIL %s: pc actual 0x%0h expected 0x%0h", t, pc, e);
      end
    end
  end

  task automatic step(input logic [2:0] o, input logic [10:0] i, input logic [7:0] d,
                      input logic we, input string tag);
    logic [12:0] nxt;
    @(negedge clk);
    op = o; imm = i; wr_data = d; latch_we = we;
    nxt = m_pc;
    case (o)
      3'd0: nxt = m_pc + 13'd1;
      3'd1: nxt = {m_latch, d};
      3'd2: nxt = {m_latch[4:3], i};
      3'd3: begin m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; nxt = {m_latch[4:3], i}; end
      3'd4: begin m_sp = m_sp - 3'd1; nxt = m_stk[m_sp]; end
      3'd5: begin m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; nxt = 13'h004; end
      default: nxt = m_pc;
    endcase
    if (we) m_latch = d[4:0];
    m_pc = nxt;
    exp_q.push_back(nxt);
    tag_q.push_back(tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pc !== 13'h0) begin errors++; $display("FAIL R1: pc actual 0x%0h expected 0x0", pc); end
    rst_n = 1'b1;
    step(3'd1, 11'h0, 8'h10, 1'b0, "R1 latch cleared");
    step(3'd0, 11'h0, 8'h00, 1'b0, "R2 step");
    step(3'd0, 11'h0, 8'h00, 1'b0, "R2 step");
    step(3'd6, 11'h0, 8'h1F, 1'b1, "R3 latch write holds pc");
    step(3'd1, 11'h0, 8'hFF, 1'b0, "R4 low write full latch");
    step(3'd0, 11'h0, 8'h00, 1'b0, "R2 wrap at top");
    step(3'd1, 11'h0, 8'h05, 1'b1, "R3 same-cycle old latch");
    step(3'd1, 11'h0, 8'hFE, 1'b0, "R4 new latch used");
    step(3'd0, 11'h0, 8'h00, 1'b0, "R4 no carry into page");
    step(3'd6, 11'h0, 8'h0A, 1'b1, "R3 latch write");
    step(3'd2, 11'h123, 8'h00, 1'b0, "R5 jump page 1");
    step(3'd6, 11'h0, 8'h17, 1'b1, "R3 latch write");
    step(3'd2, 11'h7FF, 8'h00, 1'b0, "R5 jump page 2");
    step(3'd3, 11'h055, 8'h00, 1'b0, "R6 call");
    step(3'd3, 11'h200, 8'h00, 1'b0, "R7 nested call");
    step(3'd4, 11'h0, 8'h00, 1'b0, "R7 inner return");
    step(3'd4, 11'h0, 8'h00, 1'b0, "R6 outer return");
    step(3'd5, 11'h0, 8'h00, 1'b0, "R9 interrupt vector");
    step(3'd0, 11'h0, 8'h00, 1'b0, "R2 step in handler");
    step(3'd4, 11'h0, 8'h00, 1'b0, "R9 return to interrupted pc");
    step(3'd6, 11'h0, 8'h18, 1'b1, "R10 hold");
    for (int k = 0; k < 9; k++) step(3'd3, 11'(k * 16 + 1), 8'h00, 1'b0, "R8 call chain");
    for (int k = 0; k < 9; k++) step(3'd4, 11'h0, 8'h00, 1'b0, "R8 circular return");
    step(3'd7, 11'h3AB, 8'h00, 1'b0, "R10 hold op 7");
    step(3'd6, 11'h155, 8'h00, 1'b0, "R10 hold op 6");
    @(negedge clk);
    op = 3'd6;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule